// File: doc/BRIEF.md
# Scanline Dimmer for Line-Doubled Video

This block sits in the video path directly after a line doubler and darkens chosen output lines so that a progressive picture looks like a CRT with visible scanlines. It takes one RGB pixel per clock with its active-video and sync flags. It also takes two line flags: the parity of the output line, and a marker that tells whether the line is the first or the repeated copy of a doubled source line. It returns the same pixel stream, dimmed where required, exactly one clock later.

Every option is fixed when the block is built. `THICK` selects the style, `DIM_ODD` selects the dimmed parity for the thin style, and `LEVEL` sets the strength. In the thin style, only output lines whose parity matches `DIM_ODD` are scaled by `LEVEL`. In the thick style, both copies of every doubled pair are scaled, and the repeated copy is darker than the first. Each channel is scaled by multiplying it by an unsigned factor and keeping the product shifted right by `LVL_W` bits.

Top module: `scanline_dimmer`

## Requirements
- R1: `de_o`, `hsync_o` and `vsync_o` equal `de_i`, `hsync_i` and `vsync_i` from exactly one clock earlier, and `rgb_o` is computed from the inputs of that same earlier clock.
- R2: When `de_i` is low, `rgb_o` one clock later equals `rgb_i` unchanged.
- R3: Thin style (`THICK`=0): on an active pixel whose `line_odd_i` equals `DIM_ODD`, each channel becomes floor(c*LEVEL/256). Red is `rgb[23:16]`, green is `rgb[15:8]` and blue is `rgb[7:0]` when `CH_W`=8.
- R4: Thin style: on an active pixel whose `line_odd_i` differs from `DIM_ODD`, `rgb_o` equals `rgb_i` unchanged, whatever the value of `line_rep_i`.
- R5: Thick style (`THICK`=1): every active pixel is scaled and `line_odd_i` is ignored. With `line_rep_i`=0 each channel becomes floor(c*(128+floor(LEVEL/2))/256). With `line_rep_i`=1 each channel becomes floor(c*LEVEL/256).
- R6: No output channel is ever larger than the same channel of the input it came from.
- R7: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rgb_i | input | 3*CH_W | Pixel in, packed as red, green, blue from MSB to LSB |
| de_i | input | 1 | Active-video flag |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| line_odd_i | input | 1 | Parity of the current output line |
| line_rep_i | input | 1 | High on the repeated copy of a doubled line |
| rgb_o | output | 3*CH_W | Pixel out |
| de_o | output | 1 | Delayed active-video flag |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |

## Verification
Every result of the block is due exactly one clock after the inputs that produce it: the pixel, the active-video flag and both syncs. The bench drives new inputs on the falling edge and keeps a copy of them. At the next falling edge, after the single rising edge in between, it compares the outputs with the values a bench function computes from that copy. The bench runs a thin-style instance and a thick-style instance side by side on the same stimulus, so the parity, repeat-flag and blanking paths are all covered on every cycle.

// File: rtl/scanline_pkg.sv
package scanline_pkg;

  typedef enum logic [1:0] {
    GAIN_NONE = 2'd0,
    GAIN_SOFT = 2'd1,
    GAIN_FULL = 2'd2
  } gain_e;

  // lighter factor used on the first copy in thick style
  function automatic int unsigned soft_level(int unsigned lvl, int unsigned lvl_w);
    return (32'd1 << (lvl_w - 1)) + lvl / 2;
  endfunction

endpackage

// File: rtl/scanline_gain_sel.sv
module scanline_gain_sel
  import scanline_pkg::*;
#(
  parameter bit THICK   = 1'b0,
  parameter bit DIM_ODD = 1'b1
) (
  input  logic  de_i,
  input  logic  line_odd_i,
  input  logic  line_rep_i,
  output gain_e sel_o
);

  if (THICK) begin : g_thick
    always_comb begin
      sel_o = GAIN_NONE;
      if (de_i) sel_o = line_rep_i ? GAIN_FULL : GAIN_SOFT;
    end
  end else begin : g_thin
    always_comb begin
      sel_o = GAIN_NONE;
      if (de_i && (line_odd_i == DIM_ODD)) sel_o = GAIN_FULL;
    end
  end

endmodule

// File: rtl/scanline_chan_scale.sv
module scanline_chan_scale #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned LVL_W = 8
) (
  input  logic [CH_W-1:0]  ch_i,
  input  logic [LVL_W-1:0] factor_i,
  input  logic             bypass_i,
  output logic [CH_W-1:0]  ch_o
);

  localparam int unsigned PROD_W = CH_W + LVL_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(ch_i) * PROD_W'(factor_i);
    ch_o = bypass_i ? ch_i : prod[PROD_W-1:LVL_W];
  end

endmodule

// File: rtl/scanline_dimmer.sv
module scanline_dimmer
  import scanline_pkg::*;
#(
  parameter int unsigned CH_W    = 8,
  parameter int unsigned LVL_W   = 8,
  parameter int unsigned LEVEL   = 160,
  parameter bit          DIM_ODD = 1'b1,
  parameter bit          THICK   = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [3*CH_W-1:0]   rgb_i,
  input  logic                de_i,
  input  logic                hsync_i,
  input  logic                vsync_i,
  input  logic                line_odd_i,
  input  logic                line_rep_i,
  output logic [3*CH_W-1:0]   rgb_o,
  output logic                de_o,
  output logic                hsync_o,
  output logic                vsync_o
);

  localparam int unsigned     N_CH     = 3;
  localparam int unsigned     PIX_W    = N_CH * CH_W;
  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(LEVEL);
  localparam logic [LVL_W-1:0] LVL_SOFT = LVL_W'(soft_level(LEVEL, LVL_W));

  gain_e             sel;
  logic [LVL_W-1:0]  factor;
  logic              bypass;
  logic [PIX_W-1:0]  rgb_d;

  scanline_gain_sel #(
    .THICK   (THICK),
    .DIM_ODD (DIM_ODD)
  ) i_gain_sel (
    .de_i       (de_i),
    .line_odd_i (line_odd_i),
    .line_rep_i (line_rep_i),
    .sel_o      (sel)
  );

  always_comb begin
    bypass = (sel == GAIN_NONE);
    factor = (sel == GAIN_SOFT) ? LVL_SOFT : LVL_FULL;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    scanline_chan_scale #(
      .CH_W  (CH_W),
      .LVL_W (LVL_W)
    ) i_scale (
      .ch_i     (rgb_i[c*CH_W +: CH_W]),
      .factor_i (factor),
      .bypass_i (bypass),
      .ch_o     (rgb_d[c*CH_W +: CH_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_o   <= '0;
      de_o    <= 1'b0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      rgb_o   <= rgb_d;
      de_o    <= de_i;
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
    end
  end

  // marks that one edge has passed since reset, so $past is meaningful
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_sync_delay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ({de_o, hsync_o, vsync_o} == $past({de_i, hsync_i, vsync_i})));

  p_blank_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(de_i)) |-> (rgb_o == $past(rgb_i)));

  p_thin_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!THICK && seen_q && $past(de_i) && ($past(line_odd_i) != DIM_ODD))
      |-> (rgb_o == $past(rgb_i)));

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    p_not_brighter_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q |-> (rgb_o[c*CH_W +: CH_W] <= $past(rgb_i[c*CH_W +: CH_W])));
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) p_reset_zero_r7: assert (rgb_o == '0 && !de_o && !hsync_o && !vsync_o);
  end

endmodule

// File: tb/test_scanline_dimmer.sv
module test_scanline_dimmer;

  localparam time CYC      = 20ns;
  localparam int  LVL_THIN = 160;
  localparam int  LVL_THK  = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] rgb = '0;
  logic        de = 1'b0, hs = 1'b0, vs = 1'b0, odd = 1'b0, rep = 1'b0;

  logic [23:0] rgb_a, rgb_b;
  logic        de_a, hs_a, vs_a, de_b, hs_b, vs_b;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CYC/2) clk = ~clk;

  scanline_dimmer #(.LEVEL(LVL_THIN), .DIM_ODD(1'b1), .THICK(1'b0)) i_scanline_dimmer (
    .clk_i(clk), .rst_ni(rst_n), .rgb_i(rgb), .de_i(de), .hsync_i(hs), .vsync_i(vs),
    .line_odd_i(odd), .line_rep_i(rep),
    .rgb_o(rgb_a), .de_o(de_a), .hsync_o(hs_a), .vsync_o(vs_a));

  scanline_dimmer #(.LEVEL(LVL_THK), .DIM_ODD(1'b0), .THICK(1'b1)) i_scanline_dimmer_thick (
    .clk_i(clk), .rst_ni(rst_n), .rgb_i(rgb), .de_i(de), .hsync_i(hs), .vsync_i(vs),
    .line_odd_i(odd), .line_rep_i(rep),
    .rgb_o(rgb_b), .de_o(de_b), .hsync_o(hs_b), .vsync_o(vs_b));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] exp_rgb(logic [23:0] px, bit d, bit o, bit r,
                                          bit thick, bit dim_odd, int lvl);
    logic [23:0] res;
    int f;
    if (!d) return px;
    if (thick) f = r ? lvl : 128 + lvl / 2;
    else if (o == dim_odd) f = lvl;
    else return px;
    for (int c = 0; c < 3; c++) res[c*8 +: 8] = 8'((int'(px[c*8 +: 8]) * f) >> 8);
    return res;
  endfunction

  function automatic string tag_of(bit d, bit o, bit thick, bit dim_odd);
    if (!d) return "R2";
    if (thick) return "R5";
    return (o == dim_odd) ? "R3" : "R4";
  endfunction

  // previous-cycle inputs
  logic [23:0] p_rgb;
  bit p_de, p_hs, p_vs, p_odd, p_rep;

  task automatic check_prev();
    chk("R1 sync thin",  {29'd0, de_a, hs_a, vs_a}, {29'd0, p_de, p_hs, p_vs});
    chk("R1 sync thick", {29'd0, de_b, hs_b, vs_b}, {29'd0, p_de, p_hs, p_vs});
    chk({tag_of(p_de, p_odd, 1'b0, 1'b1), " thin"}, {8'd0, rgb_a},
        {8'd0, exp_rgb(p_rgb, p_de, p_odd, p_rep, 1'b0, 1'b1, LVL_THIN)});
    chk({tag_of(p_de, p_odd, 1'b1, 1'b0), " thick"}, {8'd0, rgb_b},
        {8'd0, exp_rgb(p_rgb, p_de, p_odd, p_rep, 1'b1, 1'b0, LVL_THK)});
    for (int c = 0; c < 3; c++) begin
      chk("R6 thin",  32'(rgb_a[c*8 +: 8] <= p_rgb[c*8 +: 8]), 32'd1);
      chk("R6 thick", 32'(rgb_b[c*8 +: 8] <= p_rgb[c*8 +: 8]), 32'd1);
    end
  endtask

  task automatic step(logic [23:0] px, bit d, bit o, bit r, bit h, bit v);
    @(negedge clk);
    check_prev();
    rgb = px; de = d; odd = o; rep = r; hs = h; vs = v;
    p_rgb = px; p_de = d; p_odd = o; p_rep = r; p_hs = h; p_vs = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R7: outputs held at zero during reset despite busy inputs
    rgb = 24'hffffff; de = 1'b1; hs = 1'b1; vs = 1'b1; odd = 1'b1; rep = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 thin",  {4'd0, rgb_a, de_a, hs_a, vs_a, 1'b0}, 32'd0);
    chk("R7 thick", {4'd0, rgb_b, de_b, hs_b, vs_b, 1'b0}, 32'd0);
    rgb = '0; de = 0; hs = 0; vs = 0; odd = 0; rep = 0;
    p_rgb = '0; p_de = 0; p_hs = 0; p_vs = 0; p_odd = 0; p_rep = 0;
    @(negedge clk);
    rst_n = 1'b1;

    // directed corners: R3 full scale, R4 pass, R5 both copies, R2 blank
    step(24'hffffff, 1, 1, 0, 0, 0);
    step(24'hffffff, 1, 1, 1, 0, 0);
    step(24'hffffff, 1, 0, 0, 1, 0);
    step(24'hffffff, 1, 0, 1, 0, 1);
    step(24'h000000, 1, 1, 1, 0, 0);
    step(24'h01807f, 1, 1, 0, 0, 0);
    step(24'hff00ff, 0, 1, 1, 1, 1);
    step(24'h123456, 0, 0, 0, 0, 0);

    // raster-like random stimulus
    for (int i = 0; i < 4000; i++) begin
      int line = i / 20;
      bit o = (i % 3 == 0) ? 1'($urandom) : line[0];
      bit r = (i % 5 == 0) ? 1'($urandom) : line[0];
      step(24'($urandom), ($urandom % 8) != 0, o, r, (i % 20) < 2, (line % 30) == 0);
    end
    step('0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check_prev();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule